// File: doc/BRIEF.md
# Sub-word Memory Lane Steering

This block connects a load/store unit to a memory organised as 64-bit words. It turns a byte address and an access size of 1, 2, 4 or 8 bytes into a word index and a byte offset. It rejects any access that is not naturally aligned. For loads it pulls the addressed bytes out of the word. For stores it merges the new bytes into the stored word in a read-modify-write step. A per-request swap flag reverses the byte order of the data, and only across the bytes the access covers.

The word storage sits inside the block and is cleared by reset, so a word that has never been written reads as zero. One request is accepted per idle cycle, marked by `ready`. A load or a fault completes one cycle after it is accepted. A store needs a second cycle to write the merged word. Every completion raises `done` for one cycle.

Top module: `subword_lane_steer`

## Requirements
- R1: The word index is the byte address shifted right by 3, and the byte offset is address bits [2:0]. Lanes are little-endian: the byte at offset k occupies word bits [8k+7:8k].
- R2: `size` encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.
- R3: An accepted request whose offset is not a multiple of its width raises `fault` together with `done` for exactly the next cycle, and it leaves every stored byte unchanged.
- R4: An accepted aligned load presents the addressed bytes in `rdata` the next cycle, with `done` high. The first byte sits in bits [7:0] and the bits above the access width are zero.
- R5: An accepted aligned store raises `done` two cycles after acceptance. Only the bytes covered by the access change; all other bytes of the word keep their values.
- R6: With `swap` set, the data bytes are reversed across the access width only. A load returns byte n-1-i of the field at position i, and a store writes data byte n-1-i to address offset i, where n is the width in bytes.
- R7: After reset every word reads as zero, and `ready` is high, `done` is low and `fault` is low.
- R8: `ready` is low in the cycle after a store is accepted. A request presented while `ready` is low is ignored and changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid, taken when `ready` is high |
| req_store | input | 1 | 1 = store, 0 = load |
| addr | input | ADDR_W | Byte address |
| size | input | 2 | Access width code (R2) |
| wdata | input | 64 | Store data, right-aligned |
| swap | input | 1 | Reverse bytes within the access width |
| ready | output | 1 | Block can accept a request this cycle |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle alignment fault pulse |
| rdata | output | 64 | Load result, right-aligned and zero-extended |

## Verification
Two functions can coincide in the same cycle: the write of a pending store merge, and a new request at the block's edge. The bench holds `req` high with a different store through the merge cycle. It then checks that this second store left no trace by loading the whole target word back. It also sweeps every size, offset and swap combination over several words, including the misaligned ones, and follows each access with a full-word load. Each result is compared to a byte-array model in the bench, which checks both the lane that changed and the bytes that must not have changed.

// File: rtl/lsteer_pkg.sv
package lsteer_pkg;

    localparam int WORD_BYTES = 8;
    localparam int WORD_W     = 8 * WORD_BYTES;
    localparam int OFF_W      = $clog2(WORD_BYTES);
    localparam int SZ_W       = $clog2(OFF_W + 1);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [SZ_W-1:0]   size_t;

    typedef enum logic {ST_IDLE, ST_MERGE} state_t;

    typedef struct packed {
        off_t  off;
        size_t sz;
        logic  swap;
        word_t data;
    } lane_req_t;

    function automatic int size_bytes(size_t sz);
        return 1 << sz;
    endfunction

    function automatic word_t lane_mask(size_t sz);
        word_t m;
        m = '0;
        for (int b = 0; b < WORD_BYTES; b++) begin
            if (b < size_bytes(sz)) m[8*b +: 8] = 8'hFF;
        end
        return m;
    endfunction

    function automatic word_t byte_rev(word_t d, size_t sz);
        word_t r;
        int    n;
        n = size_bytes(sz);
        r = '0;
        for (int b = 0; b < WORD_BYTES; b++) begin
            if (b < n) r[8*b +: 8] = d[8*(n-1-b) +: 8];
        end
        return r;
    endfunction

    function automatic logic misaligned(off_t off, size_t sz);
        return (int'(off) & (size_bytes(sz) - 1)) != 0;
    endfunction

endpackage

// File: rtl/lsteer_addr_split.sv
module lsteer_addr_split
    import lsteer_pkg::*;
#(
    parameter int ADDR_W = 7,
    localparam int IDX_W = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  size_t             sz,
    output logic [IDX_W-1:0]  idx,
    output off_t              off,
    output logic              bad_align
);
    assign idx       = addr[ADDR_W-1:OFF_W];
    assign off       = addr[OFF_W-1:0];
    assign bad_align = misaligned(addr[OFF_W-1:0], sz);
endmodule

// File: rtl/lsteer_load_lane.sv
module lsteer_load_lane
    import lsteer_pkg::*;
(
    input  word_t word,
    input  off_t  off,
    input  size_t sz,
    input  logic  swap,
    output word_t lane
);
    word_t shifted;
    word_t masked;

    always_comb begin
        shifted = word >> {off, 3'b000};
        masked  = shifted & lane_mask(sz);
        lane    = swap ? byte_rev(masked, sz) : masked;
    end
endmodule

// File: rtl/lsteer_store_merge.sv
module lsteer_store_merge
    import lsteer_pkg::*;
(
    input  word_t     old_word,
    input  lane_req_t rq,
    output word_t     new_word
);
    word_t src;
    word_t field_mask;

    always_comb begin
        src        = (rq.swap ? byte_rev(rq.data, rq.sz) : rq.data) & lane_mask(rq.sz);
        field_mask = lane_mask(rq.sz) << {rq.off, 3'b000};
        new_word   = (old_word & ~field_mask) | (src << {rq.off, 3'b000});
    end
endmodule

// File: rtl/lsteer_word_store.sv
module lsteer_word_store
    import lsteer_pkg::*;
#(
    parameter int IDX_W = 4,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            rd_word,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_word
);
    word_t cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                cells[g] <= wr_word;
        end
    end

    assign rd_word = cells[rd_idx];
endmodule

// File: rtl/subword_lane_steer.sv
module subword_lane_steer
    import lsteer_pkg::*;
#(
    parameter int ADDR_W = 7,
    localparam int IDX_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [63:0]       wdata,
    input  logic              swap,
    output logic              ready,
    output logic              done,
    output logic              fault,
    output logic [63:0]       rdata
);
    state_t           state;
    lane_req_t        pend;
    logic [IDX_W-1:0] pend_idx;

    logic [IDX_W-1:0] req_idx;
    off_t             req_off;
    logic             misalign;
    logic             accept;
    logic [IDX_W-1:0] rd_idx;
    word_t            rd_word;
    word_t            load_lane;
    word_t            merged;
    logic             wr_en;

    lsteer_addr_split #(.ADDR_W(ADDR_W)) u_split (
        .addr      (addr),
        .sz        (size_t'(size)),
        .idx       (req_idx),
        .off       (req_off),
        .bad_align (misalign)
    );

    assign accept = req && (state == ST_IDLE);
    assign wr_en  = (state == ST_MERGE);
    assign rd_idx = wr_en ? pend_idx : req_idx;
    assign ready  = (state == ST_IDLE);

    lsteer_word_store #(.IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (rd_idx),
        .rd_word (rd_word),
        .wr_en   (wr_en),
        .wr_idx  (pend_idx),
        .wr_word (merged)
    );

    lsteer_load_lane u_load (
        .word (rd_word),
        .off  (req_off),
        .sz   (size_t'(size)),
        .swap (swap),
        .lane (load_lane)
    );

    lsteer_store_merge u_merge (
        .old_word (rd_word),
        .rq       (pend),
        .new_word (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            fault    <= 1'b0;
            rdata    <= '0;
            pend     <= '0;
            pend_idx <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (misalign) begin
                            fault <= 1'b1;
                            done  <= 1'b1;
                        end else if (req_store) begin
                            pend.off  <= req_off;
                            pend.sz   <= size_t'(size);
                            pend.swap <= swap;
                            pend.data <= wdata;
                            pend_idx  <= req_idx;
                            state     <= ST_MERGE;
                        end else begin
                            rdata <= load_lane;
                            done  <= 1'b1;
                        end
                    end
                end
                ST_MERGE: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lsteer_chk.sv
module lsteer_chk (
    input logic clk,
    input logic rst,
    input logic accept,
    input logic req_store,
    input logic misalign,
    input logic wr_en,
    input logic ready,
    input logic done,
    input logic fault
);
    // R3: a fault is always reported as a completion
    a_r3_fault_with_done: assert property (@(posedge clk) disable iff (rst)
        fault |-> done);

    // R3: a misaligned request never leads to a word write
    a_r3_fault_no_write: assert property (@(posedge clk) disable iff (rst)
        (accept && misalign) |=> !wr_en);

    // R5: a word write only follows an accepted aligned store
    a_r5_write_from_store: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(accept && req_store && !misalign));

    // R8: the block is busy while the merge is written
    a_r8_busy_in_merge: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !ready);

    // R4: every completion is caused by an acceptance or a merge
    a_r4_done_has_cause: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(accept) || $past(wr_en)));

    // R8: after a completion the block is ready again
    a_r8_ready_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> ready);
endmodule

bind subword_lane_steer lsteer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_store (req_store),
    .misalign  (misalign),
    .wr_en     (wr_en),
    .ready     (ready),
    .done      (done),
    .fault     (fault)
);

// File: tb/tb_subword_lane_steer.sv
module tb_subword_lane_steer;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 7;
    localparam int NBYTES     = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              req;
    logic              req_store;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        size;
    logic [63:0]       wdata;
    logic              swap;
    logic              ready;
    logic              done;
    logic              fault;
    logic [63:0]       rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [NBYTES];

    subword_lane_steer #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .req(req), .req_store(req_store),
        .addr(addr), .size(size), .wdata(wdata), .swap(swap),
        .ready(ready), .done(done), .fault(fault), .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_load(int a, int sz, bit sw);
        logic [63:0] r;
        int n;
        n = 1 << sz;
        r = '0;
        for (int i = 0; i < n; i++)
            r[8*i +: 8] = sw ? model[a+n-1-i] : model[a+i];
        return r;
    endfunction

    task automatic model_store(int a, int sz, bit sw, logic [63:0] d);
        int n;
        n = 1 << sz;
        for (int i = 0; i < n; i++)
            model[a+i] = sw ? d[8*(n-1-i) +: 8] : d[8*i +: 8];
    endtask

    // issue one request; returns at the negedge after the accepting edge
    task automatic issue(bit st, int a, int sz, logic [63:0] d, bit sw);
        @(negedge clk);
        req = 1'b1; req_store = st; addr = ADDR_W'(a);
        size = 2'(sz); wdata = d; swap = sw;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic do_load(int a, int sz, bit sw, string tag);
        logic [63:0] e;
        issue(1'b0, a, sz, '0, sw);
        e = exp_load(a, sz, sw);
        check(done === 1'b1 && fault === 1'b0, {tag, " load done"}, {62'd0, done, fault}, 64'd2);
        check(rdata === e, {tag, " load data"}, rdata, e);
    endtask

    task automatic do_store(int a, int sz, bit sw, logic [63:0] d, string tag);
        issue(1'b1, a, sz, d, sw);
        check(done === 1'b0 && ready === 1'b0, {tag, " store busy (R8)"}, {62'd0, done, ready}, 64'd0);
        @(negedge clk);
        check(done === 1'b1 && fault === 1'b0, {tag, " store done (R5)"}, {62'd0, done, fault}, 64'd2);
        model_store(a, sz, sw, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] pat;
        int w_list [3];
        for (int i = 0; i < NBYTES; i++) model[i] = 8'h00;
        req = 0; req_store = 0; addr = '0; size = '0; wdata = '0; swap = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R7 reset state
        check(ready === 1'b1 && done === 1'b0 && fault === 1'b0, "R7 reset outputs",
              {61'd0, ready, done, fault}, 64'd4);
        do_load(0, 3, 0, "R7 unwritten word 0");
        do_load(72, 3, 0, "R7 unwritten word 9");

        // R1 R2 R4 R5 R6: sweep of size, offset, swap over several words
        w_list = '{0, 5, 15};
        pat = 64'h0123_4567_89AB_CDEF;
        foreach (w_list[wi]) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int off = 0; off < 8; off++) begin
                    for (int sw = 0; sw < 2; sw++) begin
                        int a;
                        a = w_list[wi] * 8 + off;
                        pat = (pat ^ 64'h9E37_79B9_7F4A_7C15) + 64'h0000_0001_0003_0007;
                        if ((off % (1 << sz)) != 0) begin
                            // R3 misaligned store and load
                            issue(1'b1, a, sz, pat, sw[0]);
                            check(fault === 1'b1 && done === 1'b1, "R3 misaligned store fault",
                                  {62'd0, fault, done}, 64'd3);
                            @(negedge clk);
                            check(fault === 1'b0 && done === 1'b0, "R3 fault lasts one cycle",
                                  {62'd0, fault, done}, 64'd0);
                            issue(1'b0, a, sz, '0, sw[0]);
                            check(fault === 1'b1, "R3 misaligned load fault", {63'd0, fault}, 64'd1);
                            do_load(w_list[wi] * 8, 3, 0, "R3 word unchanged");
                        end else begin
                            do_store(a, sz, sw[0], pat, "R5 R6 sweep");
                            do_load(a, sz, sw[0], "R4 R6 same view");
                            do_load(a, sz, ~sw[0], "R6 opposite view");
                            do_load(w_list[wi] * 8, 3, 0, "R1 R5 full word");
                        end
                    end
                end
            end
        end

        // R8: request held during the merge cycle is ignored
        issue(1'b1, 16, 3, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0);
        req = 1'b1; req_store = 1'b1; addr = ADDR_W'(24); size = 2'd3;
        wdata = 64'h1111_2222_3333_4444; swap = 1'b0;
        check(ready === 1'b0, "R8 not ready in merge", {63'd0, ready}, 64'd0);
        @(negedge clk);
        req = 1'b0;
        model_store(16, 3, 0, 64'hAAAA_BBBB_CCCC_DDDD);
        do_load(24, 3, 0, "R8 ignored store left word 3");
        do_load(16, 3, 0, "R8 first store landed");

        // R7 word never touched still zero
        do_load(72, 3, 0, "R7 word 9 still zero");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule